// File: doc/BRIEF.md
# Bidirectional Dual-FIFO Bus Transceiver

This block joins two 18-bit buses, A and B, through a pair of independent FIFOs that carry data in opposite directions. The forward FIFO (AB) stores words taken from bus A and presents them to bus B. The return FIFO (BA) stores words taken from bus B and presents them to bus A. Each FIFO has its own load clock, unload clock and active-low reset, and these clocks need not be related to each other. Pointers cross between the clock domains as Gray code through two-flop synchronizers.

Each bus output has a source select and a drive enable. When the select is low, the bus carries the other bus's live input. When it is high, the bus carries the word most recently unloaded from the FIFO that feeds it. The select is registered on that FIFO's unload clock, so the output switches source only at a clock edge. The drive enable appears as an output-enable pin, and the pad-level tristate is left to the chip top.

Each FIFO reports empty, full, half-full and a combined almost-full/almost-empty flag. The almost flag's offset can be written through the load port while the program input is high.

Top module: `bidir_fifo_xcvr`

## Requirements
- R1: After reset, empty is 1, and full and half are 0. The almost flag is 1, because a level of 0 lies inside the offset. The offset returns to 8 even if it was programmed to another value before.
- R2: Words loaded into the AB FIFO from `a_in` appear on `b_out` in load order, one per unload strobe, while `b_src_fifo` is 1.
- R3: Words loaded into the BA FIFO from `b_in` appear on `a_out` in load order, one per unload strobe, while `a_src_fifo` is 1.
- R4: A FIFO holds at most 512 words, and full is 1 at exactly 512. A load while full is dropped, and no later unload returns that word.
- R5: An unload while empty is ignored: the bus output keeps the last unloaded word and empty stays 1.
- R6: Half is 1 when the write-side fill level is 256 or more, and 0 below that.
- R7: The almost flag is 1 when the fill level is at or below the offset, or at or above 512 minus the offset. With the default offset 8, it is 1 at levels 8 and 504, and 0 at levels 9 and 503.
- R8: A load strobe with the program input at 1 writes bits [8:0] of the input bus into the offset and stores no word. With offset 3, the flag is 1 at level 3 and 0 at level 4.
- R9: Select 0 passes the other bus's live input straight through. Select 1 drives the FIFO output word. A change of select takes effect only after the next rising edge of that FIFO's unload clock.
- R10: `b_oe` follows `b_drive` and `a_oe` follows `a_drive`.
- R11: The Gray-coded write and read pointers change by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_ld_clk | input | 1 | Load clock, AB FIFO |
| ab_ul_clk | input | 1 | Unload clock, AB FIFO |
| ab_rst_n | input | 1 | Active-low reset, AB FIFO and bus-B select |
| ab_ld_en | input | 1 | Load strobe, AB FIFO |
| ab_prog_en | input | 1 | Offset-program enable, AB FIFO |
| ab_ul_en | input | 1 | Unload strobe, AB FIFO |
| ba_ld_clk | input | 1 | Load clock, BA FIFO |
| ba_ul_clk | input | 1 | Unload clock, BA FIFO |
| ba_rst_n | input | 1 | Active-low reset, BA FIFO and bus-A select |
| ba_ld_en | input | 1 | Load strobe, BA FIFO |
| ba_prog_en | input | 1 | Offset-program enable, BA FIFO |
| ba_ul_en | input | 1 | Unload strobe, BA FIFO |
| a_in | input | 18 | Bus A receive data |
| a_out | output | 18 | Bus A drive data |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | 18 | Bus B receive data |
| b_out | output | 18 | Bus B drive data |
| b_oe | output | 1 | Bus B output enable |
| b_src_fifo | input | 1 | Bus B source: 0 live A, 1 AB FIFO |
| a_src_fifo | input | 1 | Bus A source: 0 live B, 1 BA FIFO |
| b_drive | input | 1 | Bus B drive enable |
| a_drive | input | 1 | Bus A drive enable |
| ab_empty | output | 1 | AB empty (unload domain) |
| ab_full | output | 1 | AB full (load domain) |
| ab_half | output | 1 | AB half-full (load domain) |
| ab_almost | output | 1 | AB almost-full/almost-empty (load domain) |
| ba_empty | output | 1 | BA empty (unload domain) |
| ba_full | output | 1 | BA full (load domain) |
| ba_half | output | 1 | BA half-full (load domain) |
| ba_almost | output | 1 | BA almost-full/almost-empty (load domain) |

## Verification
The hardest state to reach is the far end of the AB FIFO. Reaching it means holding 504 or more words, a load arriving while full, and the read pointer coming back to the write pointer after wrapping. This has to happen while the load and unload clocks run at unrelated periods of 10 and 14 time units. The stimulus starts from a FIFO that has already been partly used, so the pointers do not begin at zero. It then fills the FIFO one word at a time and samples the flags at levels 8, 9, 255, 256, 503, 504, 511 and 512. Next it pushes one word while full and drains all 512 words against the scoreboard, which shows that the dropped word never surfaces.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int PTR_MAX = 16;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_FIFO = 1'b1
  } src_e;

  function automatic logic [PTR_MAX-1:0] bin2gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // level near either end of the FIFO, measured against the offset
  function automatic logic almost_hit(input logic [PTR_MAX-1:0] fill,
                                      input logic [PTR_MAX-1:0] off,
                                      input logic [PTR_MAX-1:0] depth);
    return (fill <= off) || (fill >= depth - off);
  endfunction

endpackage

// File: rtl/bfx_sync.sv
module bfx_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/bfx_fifo.sv
module bfx_fifo
  import bfx_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8
) (
  input  logic             ld_clk,
  input  logic             ul_clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             prog_en,
  input  logic             ul_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             half,
  output logic             almost
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [WIDTH-1:0] mem [DEPTH];

  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] rgray_w, wgray_r, rptr_bin_w, fill_w;
  logic [AW-1:0] off_q;
  logic [WIDTH-1:0] dout_q;

  // named events
  logic do_wr, do_prog, wr_blocked, do_rd, rd_blocked;

  assign do_prog    = ld_en && prog_en;
  assign do_wr      = ld_en && !prog_en && !full;
  assign wr_blocked = ld_en && !prog_en && full;
  assign do_rd      = ul_en && !empty;
  assign rd_blocked = ul_en && empty;

  // ---------------- load domain ----------------
  bfx_sync #(.W(PW)) u_rsync (
    .clk   (ld_clk),
    .rst_n (rst_n),
    .d     (rptr_gray),
    .q     (rgray_w)
  );

  assign rptr_bin_w = PW'(gray2bin(PTR_MAX'(rgray_w)));
  assign fill_w     = wptr_bin - rptr_bin_w;
  assign full       = (fill_w == PW'(DEPTH));
  assign half       = (fill_w >= PW'(HALF));
  assign almost     = almost_hit(PTR_MAX'(fill_w), PTR_MAX'(off_q), PTR_MAX'(DEPTH));

  always_ff @(posedge ld_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      off_q     <= AW'(DEF_OFF);
    end else begin
      if (do_prog) begin
        off_q <= din[AW-1:0];
      end
      if (do_wr) begin
        wptr_bin  <= wptr_bin + 1'b1;
        wptr_gray <= PW'(bin2gray(PTR_MAX'(wptr_bin + 1'b1)));
      end
    end
  end

  always_ff @(posedge ld_clk) begin
    if (do_wr) begin
      mem[wptr_bin[AW-1:0]] <= din;
    end
  end

  // ---------------- unload domain ----------------
  bfx_sync #(.W(PW)) u_wsync (
    .clk   (ul_clk),
    .rst_n (rst_n),
    .d     (wptr_gray),
    .q     (wgray_r)
  );

  assign empty = (rptr_gray == wgray_r);

  always_ff @(posedge ul_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      dout_q    <= '0;
    end else if (do_rd) begin
      dout_q    <= mem[rptr_bin[AW-1:0]];
      rptr_bin  <= rptr_bin + 1'b1;
      rptr_gray <= PW'(bin2gray(PTR_MAX'(rptr_bin + 1'b1)));
    end
  end

  assign dout = dout_q;

  // ---------------- assertions ----------------
  // R4
  wr_full_drop_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    wr_blocked |=> $stable(wptr_bin));

  // R4
  fill_bound_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    fill_w <= PW'(DEPTH));

  // R5
  rd_empty_hold_chk: assert property (@(posedge ul_clk) disable iff (!rst_n)
    rd_blocked |=> ($stable(rptr_bin) && $stable(dout_q)));

  // R8
  prog_no_store_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    do_prog |=> $stable(wptr_bin));

  // R11
  wgray_step_chk: assert property (@(posedge ld_clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  // R11
  rgray_step_chk: assert property (@(posedge ul_clk) disable iff (!rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

endmodule

// File: rtl/bfx_path_mux.sv
module bfx_path_mux
  import bfx_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             drive_en,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe
);

  src_e sel_q;

  // select held in a flop so the source changes cleanly at one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SRC_LIVE;
    else        sel_q <= src_e'(src_sel);
  end

  always_comb begin
    unique case (sel_q)
      SRC_FIFO: bus_out = stored;
      default:  bus_out = live;
    endcase
  end

  assign bus_oe = drive_en;

  // R9
  sel_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(src_sel) |=> (sel_q == src_e'($past(src_sel))));

endmodule

// File: rtl/bidir_fifo_xcvr.sv
module bidir_fifo_xcvr
  import bfx_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8
) (
  input  logic             ab_ld_clk,
  input  logic             ab_ul_clk,
  input  logic             ab_rst_n,
  input  logic             ab_ld_en,
  input  logic             ab_prog_en,
  input  logic             ab_ul_en,
  input  logic             ba_ld_clk,
  input  logic             ba_ul_clk,
  input  logic             ba_rst_n,
  input  logic             ba_ld_en,
  input  logic             ba_prog_en,
  input  logic             ba_ul_en,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             b_src_fifo,
  input  logic             a_src_fifo,
  input  logic             b_drive,
  input  logic             a_drive,
  output logic             ab_empty,
  output logic             ab_full,
  output logic             ab_half,
  output logic             ab_almost,
  output logic             ba_empty,
  output logic             ba_full,
  output logic             ba_half,
  output logic             ba_almost
);

  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0] ld_clk, ul_clk, rst_n, ld_en, prog_en, ul_en;
  logic [NDIR-1:0] sel, drv, oe, empty, full, half, almost;
  logic [WIDTH-1:0] din   [NDIR];
  logic [WIDTH-1:0] dout  [NDIR];
  logic [WIDTH-1:0] bus_o [NDIR];

  assign ld_clk  = {ba_ld_clk,  ab_ld_clk};
  assign ul_clk  = {ba_ul_clk,  ab_ul_clk};
  assign rst_n   = {ba_rst_n,   ab_rst_n};
  assign ld_en   = {ba_ld_en,   ab_ld_en};
  assign prog_en = {ba_prog_en, ab_prog_en};
  assign ul_en   = {ba_ul_en,   ab_ul_en};
  assign sel     = {a_src_fifo, b_src_fifo};
  assign drv     = {a_drive,    b_drive};
  assign din[0]  = a_in;
  assign din[1]  = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    bfx_fifo #(
      .WIDTH   (WIDTH),
      .DEPTH   (DEPTH),
      .DEF_OFF (DEF_OFF)
    ) u_fifo (
      .ld_clk  (ld_clk[d]),
      .ul_clk  (ul_clk[d]),
      .rst_n   (rst_n[d]),
      .ld_en   (ld_en[d]),
      .prog_en (prog_en[d]),
      .ul_en   (ul_en[d]),
      .din     (din[d]),
      .dout    (dout[d]),
      .empty   (empty[d]),
      .full    (full[d]),
      .half    (half[d]),
      .almost  (almost[d])
    );

    bfx_path_mux #(.WIDTH(WIDTH)) u_mux (
      .clk      (ul_clk[d]),
      .rst_n    (rst_n[d]),
      .src_sel  (sel[d]),
      .drive_en (drv[d]),
      .live     (din[d]),
      .stored   (dout[d]),
      .bus_out  (bus_o[d]),
      .bus_oe   (oe[d])
    );
  end

  assign b_out     = bus_o[0];
  assign b_oe      = oe[0];
  assign a_out     = bus_o[1];
  assign a_oe      = oe[1];
  assign ab_empty  = empty[0];
  assign ab_full   = full[0];
  assign ab_half   = half[0];
  assign ab_almost = almost[0];
  assign ba_empty  = empty[1];
  assign ba_full   = full[1];
  assign ba_half   = half[1];
  assign ba_almost = almost[1];

endmodule

// File: tb/bidir_fifo_xcvr_tb.sv
module bidir_fifo_xcvr_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 14;
  localparam int W = 18;

  logic fclk = 1'b0;
  logic sclk = 1'b0;
  always #(CLK_PERIOD/2)  fclk = ~fclk;
  always #(SLOW_PERIOD/2) sclk = ~sclk;

  logic ab_rst_n, ba_rst_n;
  logic ab_ld_en, ab_prog_en, ab_ul_en, ba_ld_en, ba_prog_en, ba_ul_en;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, b_src_fifo, a_src_fifo, b_drive, a_drive;
  logic ab_empty, ab_full, ab_half, ab_almost;
  logic ba_empty, ba_full, ba_half, ba_almost;

  bidir_fifo_xcvr u_dut (
    .ab_ld_clk (fclk), .ab_ul_clk (sclk), .ab_rst_n (ab_rst_n),
    .ab_ld_en (ab_ld_en), .ab_prog_en (ab_prog_en), .ab_ul_en (ab_ul_en),
    .ba_ld_clk (sclk), .ba_ul_clk (fclk), .ba_rst_n (ba_rst_n),
    .ba_ld_en (ba_ld_en), .ba_prog_en (ba_prog_en), .ba_ul_en (ba_ul_en),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
    .b_src_fifo (b_src_fifo), .a_src_fifo (a_src_fifo),
    .b_drive (b_drive), .a_drive (a_drive),
    .ab_empty (ab_empty), .ab_full (ab_full), .ab_half (ab_half), .ab_almost (ab_almost),
    .ba_empty (ba_empty), .ba_full (ba_full), .ba_half (ba_half), .ba_almost (ba_almost)
  );

  int total = 0;
  int bad   = 0;
  logic [W-1:0] q_ab [$];
  logic [W-1:0] q_ba [$];
  logic [W-1:0] last_b;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: load one word into AB, scoreboard records it if it is accepted
  task automatic wr_ab(input logic [W-1:0] v);
    @(negedge fclk);
    a_in = v; ab_ld_en = 1'b1;
    if (!ab_full) q_ab.push_back(v);
    @(negedge fclk);
    ab_ld_en = 1'b0;
  endtask

  task automatic wr_ba(input logic [W-1:0] v);
    @(negedge sclk);
    b_in = v; ba_ld_en = 1'b1;
    if (!ba_full) q_ba.push_back(v);
    @(negedge sclk);
    ba_ld_en = 1'b0;
  endtask

  task automatic prog_ab(input logic [W-1:0] v);
    @(negedge fclk);
    a_in = v; ab_prog_en = 1'b1; ab_ld_en = 1'b1;
    @(negedge fclk);
    ab_prog_en = 1'b0; ab_ld_en = 1'b0;
  endtask

  // monitor: unload one word and compare with the scoreboard head
  task automatic rd_ab(input string req);
    logic [W-1:0] exp;
    @(negedge sclk);
    while (ab_empty) @(negedge sclk);
    ab_ul_en = 1'b1;
    @(negedge sclk);
    ab_ul_en = 1'b0;
    exp = (q_ab.size() > 0) ? q_ab.pop_front() : '1;
    check(b_out == exp, req, 32'(b_out), 32'(exp));
    last_b = b_out;
  endtask

  task automatic rd_ba(input string req);
    logic [W-1:0] exp;
    @(negedge fclk);
    while (ba_empty) @(negedge fclk);
    ba_ul_en = 1'b1;
    @(negedge fclk);
    ba_ul_en = 1'b0;
    exp = (q_ba.size() > 0) ? q_ba.pop_front() : '1;
    check(a_out == exp, req, 32'(a_out), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ab_rst_n = 1'b0; ba_rst_n = 1'b0;
    ab_ld_en = 0; ab_prog_en = 0; ab_ul_en = 0;
    ba_ld_en = 0; ba_prog_en = 0; ba_ul_en = 0;
    a_in = '0; b_in = '0;
    b_src_fifo = 0; a_src_fifo = 0; b_drive = 0; a_drive = 0;
    repeat (4) @(negedge fclk);
    // R1 reset state
    check(ab_empty == 1, "R1 ab_empty", 32'(ab_empty), 1);
    check(ab_full == 0 && ab_half == 0, "R1 ab_full/half", {ab_full, ab_half}, 0);
    check(ab_almost == 1, "R1 ab_almost", 32'(ab_almost), 1);
    check(ba_empty == 1 && ba_full == 0 && ba_half == 0, "R1 ba flags",
          {ba_empty, ba_full, ba_half}, 32'b100);
    #1; ab_rst_n = 1'b1; ba_rst_n = 1'b1;
    repeat (3) @(negedge fclk);

    // R9 / R10 live pass-through and enables
    b_drive = 1; a_drive = 0;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    #1;
    check(b_out == a_in, "R9 live A->B", 32'(b_out), 32'(a_in));
    check(a_out == b_in, "R9 live B->A", 32'(a_out), 32'(b_in));
    check(b_oe == 1 && a_oe == 0, "R10 oe", {b_oe, a_oe}, 32'b10);
    a_drive = 1; b_drive = 0; #1;
    check(a_oe == 1 && b_oe == 0, "R10 oe swap", {a_oe, b_oe}, 32'b10);
    b_drive = 1;

    // R2 ordered transfer A->B
    b_src_fifo = 1;
    repeat (2) @(negedge sclk);
    for (int i = 0; i < 5; i++) wr_ab(W'(18'h100 + i * 7));
    for (int i = 0; i < 5; i++) rd_ab("R2 order");

    // R9 select change waits for an unload clock edge
    @(negedge sclk);
    b_src_fifo = 0; a_in = 18'h3C3C3; #1;
    check(b_out == last_b, "R9 sel before edge", 32'(b_out), 32'(last_b));
    @(negedge sclk);
    check(b_out == 18'h3C3C3, "R9 sel after edge", 32'(b_out), 32'h3C3C3);
    b_src_fifo = 1;
    repeat (2) @(negedge sclk);

    // R5 unload while empty
    ab_ul_en = 1; @(negedge sclk); ab_ul_en = 0;
    @(negedge sclk);
    check(b_out == last_b, "R5 empty read hold", 32'(b_out), 32'(last_b));
    check(ab_empty == 1, "R5 still empty", 32'(ab_empty), 1);

    // R4 R6 R7 fill to the top
    for (int n = 1; n <= 512; n++) begin
      wr_ab(W'(n));
      if (n == 8)   check(ab_almost == 1, "R7 level 8",   32'(ab_almost), 1);
      if (n == 9)   check(ab_almost == 0, "R7 level 9",   32'(ab_almost), 0);
      if (n == 255) check(ab_half == 0,   "R6 level 255", 32'(ab_half), 0);
      if (n == 256) check(ab_half == 1,   "R6 level 256", 32'(ab_half), 1);
      if (n == 503) check(ab_almost == 0, "R7 level 503", 32'(ab_almost), 0);
      if (n == 504) check(ab_almost == 1, "R7 level 504", 32'(ab_almost), 1);
      if (n == 511) check(ab_full == 0,   "R4 level 511", 32'(ab_full), 0);
      if (n == 512) check(ab_full == 1,   "R4 level 512", 32'(ab_full), 1);
    end
    wr_ab(18'h3FFFF);
    check(ab_full == 1, "R4 full after drop", 32'(ab_full), 1);
    for (int n = 0; n < 512; n++) rd_ab("R4 drain");
    repeat (3) @(negedge sclk);
    check(ab_empty == 1, "R4 dropped word absent", 32'(ab_empty), 1);
    repeat (6) @(negedge fclk);
    check(ab_full == 0 && ab_almost == 1, "R4 flags after drain",
          {ab_full, ab_almost}, 32'b01);

    // R8 program offset 3
    prog_ab(18'h00003);
    repeat (6) @(negedge sclk);
    check(ab_empty == 1, "R8 prog stores no word", 32'(ab_empty), 1);
    for (int n = 0; n < 3; n++) wr_ab(W'(18'h200 + n));
    check(ab_almost == 1, "R8 level 3", 32'(ab_almost), 1);
    wr_ab(18'h203);
    check(ab_almost == 0, "R8 level 4", 32'(ab_almost), 0);
    for (int n = 0; n < 4; n++) rd_ab("R8 drain");

    // R1 reset restores offset 8
    @(negedge fclk); #1 ab_rst_n = 1'b0;
    @(negedge fclk);
    check(ab_empty == 1, "R1 empty on reset", 32'(ab_empty), 1);
    #1 ab_rst_n = 1'b1;
    q_ab.delete();
    repeat (3) @(negedge fclk);
    for (int n = 0; n < 8; n++) wr_ab(W'(18'h300 + n));
    check(ab_almost == 1, "R1 default offset restored", 32'(ab_almost), 1);
    for (int n = 0; n < 8; n++) rd_ab("R2 after reset");

    // R3 B->A path
    a_src_fifo = 1;
    repeat (2) @(negedge fclk);
    for (int i = 0; i < 4; i++) wr_ba(W'(18'h0A5A5 ^ (i << 3)));
    for (int i = 0; i < 4; i++) rd_ba("R3 order");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule